// File: doc/BRIEF.md
# Two-Sequence PWM Playback Controller

This block sequences playback for a multi-channel pulse-width modulator. It takes single-cycle task pulses (start sequence 0, start sequence 1, stop, step), tells a downstream sequence decoder which of two sequences to read and when to reload it from its first value, and tells the pulse generator when to cease output. Strobes come back from the decoder when the last value of a sequence has been fetched, and from the pulse generator at the end of every PWM period.

With a nonzero loop count the controller plays sequence 0 and then sequence 1, and repeats that pair the programmed number of times. It raises a loops-done event when the last pair completes and marks the final sequence so the decoder can skip its per-value repeats and trailing delay. With a loop count of zero the started sequence plays once. Seven event pulses are latched into sticky flags, cleared by a write-one-to-clear strobe, and a masked OR of the flags drives the interrupt. Five shortcut enables let an event fire a task inside the block.

Top module: `pwm_playback_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after, run_o, stop_req_o, seq_load_o, final_pass_o, evt_o, flags_o and irq_o are all low.
- R2: A start task is taken at a clock edge. In the following cycle run_o is high, seq_sel_o names the sequence, seq_load_o pulses and the matching started event pulses. A start while running restarts from value 0 and reloads the loop count. A start beats a stop in the same cycle, and sequence 0 beats sequence 1 when both starts arrive together.
- R3: A seq_done_i strobe while playing pulses the end event of the current sequence in the next cycle. With a loop count of zero the controller then holds: run_o stays high and later seq_done_i strobes raise no event.
- R4: With loop count N above zero, each completion of sequence 0 switches to sequence 1 (reload and started-1 pulse) and each completion of sequence 1 on a non-final pass switches back to sequence 0. The Nth completion of sequence 1 pulses end-1 and loops-done together and the controller holds. A playback started on sequence 1 plays sequence 1 alone in its first pass, so it ends after 2N-1 strobes instead of 2N.
- R5: final_pass_o is high exactly while sequence 1 of the last pass is playing in loop mode. A seq_done_i strobe in that state leads to the loops-done event.
- R6: A stop while playing or holding raises stop_req_o in the next cycle, and run_o stays high until a period_end_i strobe. In the cycle after that strobe run_o is low and the stopped event pulses. A stop while idle pulses the stopped event in the next cycle.
- R7: A period_end_i strobe while run_o is high pulses the period-end event in the next cycle. While idle it raises nothing.
- R8: Shortcut enable bits: 0 end-0 to stop, 1 end-1 to stop, 2 loops-done to start 0, 3 loops-done to start 1, 4 loops-done to stop. An enabled shortcut acts as a task in the cycle its event pulse is on the output, so its effect shows one cycle later. A start shortcut beats a stop shortcut, and start 0 beats start 1.
- R9: Event bit order in evt_o, flags_o, int_en_i and evt_clr_i: 0 stopped, 1 started-0, 2 started-1, 3 end-0, 4 end-1, 5 period end, 6 loops done. A flag rises in the same cycle as its event pulse and stays set until an evt_clr_i bit clears it. A clear and a new event in the same cycle leave the flag set.
- R10: irq_o is high exactly when some flag and its int_en_i bit are both set.
- R11: step_o follows task_step_i in the same cycle while playing, and is low in any other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| task_start0_i | input | 1 | Start-sequence-0 task pulse |
| task_start1_i | input | 1 | Start-sequence-1 task pulse |
| task_stop_i | input | 1 | Stop task pulse |
| task_step_i | input | 1 | Step task pulse for the decoder |
| loop_cnt_i | input | LOOP_W | Passes of the sequence pair, 0 for single play |
| short_en_i | input | 5 | Shortcut enables |
| int_en_i | input | 7 | Interrupt enables per event |
| evt_clr_i | input | 7 | Write-one-to-clear strobes for the flags |
| seq_done_i | input | 1 | Decoder strobe: last value of the sequence fetched |
| period_end_i | input | 1 | Pulse generator strobe: PWM period ended |
| run_o | output | 1 | Pulse generation enabled |
| seq_sel_o | output | 1 | Sequence the decoder reads |
| seq_load_o | output | 1 | Decoder reload from value 0 |
| step_o | output | 1 | Step request forwarded to the decoder |
| stop_req_o | output | 1 | Stop pending, cease at period end |
| final_pass_o | output | 1 | Last sequence of the last pass: skip repeats and end delay |
| evt_o | output | 7 | Event pulses |
| flags_o | output | 7 | Sticky event flags |
| irq_o | output | 1 | Interrupt |

## Verification
Task and decoder strobes change state at the sampling edge, so run_o, seq_sel_o, seq_load_o, final_pass_o, evt_o and flags_o are due one cycle after the stimulus. A shortcut's effect comes one cycle after its event pulse, and irq_o and step_o follow their inputs in the same cycle. The bench drives every input just after a falling edge and reads results at the next falling edge, after exactly one rising edge. It reads the combinational outputs a moment after driving. Random loop counts and start sequences are scored against a bench function that gives the strobe count up to loops-done.

// File: rtl/pwm_seq_pkg.sv
package pwm_seq_pkg;
  localparam int NUM_EVT   = 7;
  localparam int NUM_SHORT = 5;

  localparam int EV_STOPPED  = 0;
  localparam int EV_STARTED0 = 1;
  localparam int EV_STARTED1 = 2;
  localparam int EV_END0     = 3;
  localparam int EV_END1     = 4;
  localparam int EV_PERIOD   = 5;
  localparam int EV_LOOPS    = 6;

  localparam int SC_END0_STOP    = 0;
  localparam int SC_END1_STOP    = 1;
  localparam int SC_LOOPS_START0 = 2;
  localparam int SC_LOOPS_START1 = 3;
  localparam int SC_LOOPS_STOP   = 4;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_PLAY     = 2'd1,
    ST_HOLD     = 2'd2,
    ST_STOPPING = 2'd3
  } play_st_e;
endpackage

// File: rtl/pwm_task_arb.sv
module pwm_task_arb
  import pwm_seq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ext_start0,
  input  logic                 ext_start1,
  input  logic                 ext_stop,
  input  logic                 ev_end0,
  input  logic                 ev_end1,
  input  logic                 ev_loops,
  input  logic [NUM_SHORT-1:0] short_en,
  output logic                 start_req,
  output logic                 start_sel,
  output logic                 stop_req
);
  logic sc_start0, sc_start1, sc_stop;

  assign sc_start0 = ev_loops & short_en[SC_LOOPS_START0];
  assign sc_start1 = ev_loops & short_en[SC_LOOPS_START1];
  assign sc_stop   = (ev_end0 & short_en[SC_END0_STOP]) |
                     (ev_end1 & short_en[SC_END1_STOP]) |
                     (ev_loops & short_en[SC_LOOPS_STOP]);

  assign start_req = ext_start0 | ext_start1 | sc_start0 | sc_start1;

  always_comb begin
    if (ext_start0)      start_sel = 1'b0;
    else if (ext_start1) start_sel = 1'b1;
    else if (sc_start0)  start_sel = 1'b0;
    else                 start_sel = 1'b1;
  end

  assign stop_req = ext_stop | sc_stop;

  // R2
  ext_start1_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_start1 && !ext_start0) |-> (start_req && start_sel));

  // R8
  loops_start0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_loops && short_en[SC_LOOPS_START0] && !ext_start1) |-> (start_req && !start_sel));
endmodule

// File: rtl/pwm_play_fsm.sv
module pwm_play_fsm
  import pwm_seq_pkg::*;
#(
  parameter int LOOP_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_req,
  input  logic               start_sel,
  input  logic               stop_req,
  input  logic               seq_done,
  input  logic               period_end,
  input  logic [LOOP_W-1:0]  loop_cnt,
  output play_st_e           st_o,
  output logic               sel_o,
  output logic               load_o,
  output logic               final_pass_o,
  output logic [NUM_EVT-1:0] evt_nxt_o,
  output logic [NUM_EVT-1:0] evt_o
);
  play_st_e           st_q, st_n;
  logic               sel_q, sel_n;
  logic [LOOP_W-1:0]  left_q, left_n;
  logic               load_q, load_n;
  logic [NUM_EVT-1:0] evt_q, evt_n;
  logic               active;

  function automatic logic is_last_pass(input logic [LOOP_W-1:0] left);
    return left == LOOP_W'(1);
  endfunction

  function automatic logic [LOOP_W-1:0] one_less(input logic [LOOP_W-1:0] left);
    return left - LOOP_W'(1);
  endfunction

  assign active = (st_q == ST_PLAY) || (st_q == ST_HOLD);

  always_comb begin
    st_n   = st_q;
    sel_n  = sel_q;
    left_n = left_q;
    load_n = 1'b0;
    evt_n  = '0;
    if (period_end && st_q != ST_IDLE) evt_n[EV_PERIOD] = 1'b1;
    if (start_req) begin
      st_n   = ST_PLAY;
      sel_n  = start_sel;
      left_n = loop_cnt;
      load_n = 1'b1;
      evt_n[start_sel ? EV_STARTED1 : EV_STARTED0] = 1'b1;
    end else begin
      if (st_q == ST_PLAY && seq_done) begin
        evt_n[sel_q ? EV_END1 : EV_END0] = 1'b1;
        if (left_q == '0) begin
          st_n = ST_HOLD;
        end else if (!sel_q) begin
          sel_n  = 1'b1;
          load_n = 1'b1;
          evt_n[EV_STARTED1] = 1'b1;
        end else if (is_last_pass(left_q)) begin
          left_n = '0;
          st_n   = ST_HOLD;
          evt_n[EV_LOOPS] = 1'b1;
        end else begin
          left_n = one_less(left_q);
          sel_n  = 1'b0;
          load_n = 1'b1;
          evt_n[EV_STARTED0] = 1'b1;
        end
      end
      if (stop_req && active) begin
        st_n   = ST_STOPPING;
        sel_n  = sel_q;
        load_n = 1'b0;
        evt_n[EV_STARTED0] = 1'b0;
        evt_n[EV_STARTED1] = 1'b0;
      end else if (stop_req && st_q == ST_IDLE) begin
        evt_n[EV_STOPPED] = 1'b1;
      end
      if (st_q == ST_STOPPING && period_end) begin
        st_n = ST_IDLE;
        evt_n[EV_STOPPED] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sel_q  <= 1'b0;
      left_q <= '0;
      load_q <= 1'b0;
      evt_q  <= '0;
    end else begin
      st_q   <= st_n;
      sel_q  <= sel_n;
      left_q <= left_n;
      load_q <= load_n;
      evt_q  <= evt_n;
    end
  end

  assign st_o         = st_q;
  assign sel_o        = sel_q;
  assign load_o       = load_q;
  assign final_pass_o = (st_q == ST_PLAY) && sel_q && is_last_pass(left_q);
  assign evt_nxt_o    = evt_n;
  assign evt_o        = evt_q;

  // R2
  load_in_play_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_q |-> (st_q == ST_PLAY));

  // R6
  stopped_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q[EV_STOPPED] |-> (st_q == ST_IDLE));

  // R4
  one_start_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(evt_q[EV_STARTED1:EV_STARTED0]));

  // R4
  loops_no_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_req |=> (left_q <= $past(left_q)));

  // R5
  final_to_loops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (final_pass_o && seq_done && !start_req && !stop_req) |=> evt_q[EV_LOOPS]);
endmodule

// File: rtl/pwm_evt_flags.sv
module pwm_evt_flags
  import pwm_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_nxt,
  input  logic [NUM_EVT-1:0] clr,
  input  logic [NUM_EVT-1:0] int_en,
  output logic [NUM_EVT-1:0] flags_o,
  output logic               irq_o
);
  logic [NUM_EVT-1:0] flags_q;

  function automatic logic any_pending(input logic [NUM_EVT-1:0] f,
                                       input logic [NUM_EVT-1:0] en);
    return |(f & en);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~clr) | evt_nxt;
  end

  assign flags_o = flags_q;
  assign irq_o   = any_pending(flags_q, int_en);

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_flag_chk
    // R9
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_nxt[i] |=> flags_q[i]);
    // R9
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_q[i] && !clr[i]) |=> flags_q[i]);
  end

  // R10
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (flags_q != '0));
endmodule

// File: rtl/pwm_playback_ctrl.sv
module pwm_playback_ctrl
  import pwm_seq_pkg::*;
#(
  parameter int LOOP_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 task_start0_i,
  input  logic                 task_start1_i,
  input  logic                 task_stop_i,
  input  logic                 task_step_i,
  input  logic [LOOP_W-1:0]    loop_cnt_i,
  input  logic [NUM_SHORT-1:0] short_en_i,
  input  logic [NUM_EVT-1:0]   int_en_i,
  input  logic [NUM_EVT-1:0]   evt_clr_i,
  input  logic                 seq_done_i,
  input  logic                 period_end_i,
  output logic                 run_o,
  output logic                 seq_sel_o,
  output logic                 seq_load_o,
  output logic                 step_o,
  output logic                 stop_req_o,
  output logic                 final_pass_o,
  output logic [NUM_EVT-1:0]   evt_o,
  output logic [NUM_EVT-1:0]   flags_o,
  output logic                 irq_o
);
  logic               start_req, start_sel, stop_req;
  play_st_e           st;
  logic [NUM_EVT-1:0] evt_nxt;

  pwm_task_arb u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_start0 (task_start0_i),
    .ext_start1 (task_start1_i),
    .ext_stop   (task_stop_i),
    .ev_end0    (evt_o[EV_END0]),
    .ev_end1    (evt_o[EV_END1]),
    .ev_loops   (evt_o[EV_LOOPS]),
    .short_en   (short_en_i),
    .start_req  (start_req),
    .start_sel  (start_sel),
    .stop_req   (stop_req)
  );

  pwm_play_fsm #(.LOOP_W(LOOP_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_req    (start_req),
    .start_sel    (start_sel),
    .stop_req     (stop_req),
    .seq_done     (seq_done_i),
    .period_end   (period_end_i),
    .loop_cnt     (loop_cnt_i),
    .st_o         (st),
    .sel_o        (seq_sel_o),
    .load_o       (seq_load_o),
    .final_pass_o (final_pass_o),
    .evt_nxt_o    (evt_nxt),
    .evt_o        (evt_o)
  );

  pwm_evt_flags u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_nxt (evt_nxt),
    .clr     (evt_clr_i),
    .int_en  (int_en_i),
    .flags_o (flags_o),
    .irq_o   (irq_o)
  );

  assign run_o      = (st != ST_IDLE);
  assign stop_req_o = (st == ST_STOPPING);
  assign step_o     = task_step_i && (st == ST_PLAY);

  // R11
  step_only_playing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |-> (run_o && !stop_req_o));

  // R6
  run_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req_o && !period_end_i && !start_req) |=> run_o);
endmodule

// File: tb/pwm_playback_ctrl_tb.sv
module pwm_playback_ctrl_tb;
  localparam int LW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          task_start0, task_start1, task_stop, task_step;
  logic [LW-1:0] loop_cnt;
  logic [4:0]    short_en;
  logic [6:0]    int_en, evt_clr;
  logic          seq_done, period_end;
  logic          run_o, seq_sel_o, seq_load_o, step_o, stop_req_o, final_pass_o, irq_o;
  logic [6:0]    evt_o, flags_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  pwm_playback_ctrl #(.LOOP_W(LW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .task_start0_i(task_start0), .task_start1_i(task_start1),
    .task_stop_i(task_stop), .task_step_i(task_step),
    .loop_cnt_i(loop_cnt), .short_en_i(short_en), .int_en_i(int_en),
    .evt_clr_i(evt_clr), .seq_done_i(seq_done), .period_end_i(period_end),
    .run_o(run_o), .seq_sel_o(seq_sel_o), .seq_load_o(seq_load_o),
    .step_o(step_o), .stop_req_o(stop_req_o), .final_pass_o(final_pass_o),
    .evt_o(evt_o), .flags_o(flags_o), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: inputs set beforehand are sampled at the rising edge, strobes dropped after
  task automatic step1();
    @(negedge clk);
    task_start0 = 0; task_start1 = 0; task_stop = 0; task_step = 0;
    seq_done = 0; period_end = 0; evt_clr = '0;
  endtask

  function automatic int strobes_to_done(input int n, input bit s);
    return s ? 2 * n - 1 : 2 * n;
  endfunction

  function automatic int end0_count(input int n, input bit s);
    return s ? n - 1 : n;
  endfunction

  function automatic bit exp_irq(input logic [6:0] f, input logic [6:0] en);
    return (f & en) != 0;
  endfunction

  task automatic to_idle();
    task_stop = 1; step1();
    period_end = 1; step1();
    check("R6 back to idle", run_o, 0);
  endtask

  task automatic clear_all();
    evt_clr = 7'h7f; step1();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int cnt, e0, n;
    bit s;
    void'($urandom(32'd4711));
    rst_n = 0; task_start0 = 0; task_start1 = 0; task_stop = 0; task_step = 0;
    loop_cnt = '0; short_en = '0; int_en = '0; evt_clr = '0;
    seq_done = 0; period_end = 0;
    repeat (3) @(negedge clk);
    check("R1 run in reset", run_o, 0);
    rst_n = 1;
    step1();
    check("R1 run", run_o, 0);
    check("R1 stop_req", stop_req_o, 0);
    check("R1 load", seq_load_o, 0);
    check("R1 final", final_pass_o, 0);
    check("R1 evt", evt_o, 0);
    check("R1 flags", flags_o, 0);
    check("R1 irq", irq_o, 0);

    // single play
    loop_cnt = 0;
    task_start0 = 1; step1();
    check("R2 run", run_o, 1);
    check("R2 sel", seq_sel_o, 0);
    check("R2 load", seq_load_o, 1);
    check("R2 started0 evt", evt_o, 7'h02);
    check("R9 flag same cycle", flags_o, 7'h02);
    task_step = 1; #1;
    check("R11 step while playing", step_o, 1);
    step1();
    seq_done = 1; step1();
    check("R3 end0 evt", evt_o, 7'h08);
    check("R3 no reload", seq_load_o, 0);
    seq_done = 1; step1();
    check("R3 hold ignores done", evt_o, 0);
    check("R3 hold keeps run", run_o, 1);
    task_step = 1; #1;
    check("R11 no step in hold", step_o, 0);
    step1();
    task_stop = 1; step1();
    check("R6 stop_req", stop_req_o, 1);
    step1(); step1();
    check("R6 run until period end", run_o, 1);
    period_end = 1; step1();
    check("R6 run low", run_o, 0);
    check("R6 R7 stopped and period evt", evt_o, 7'h21);
    period_end = 1; step1();
    check("R7 idle period ignored", evt_o, 0);
    task_stop = 1; step1();
    check("R6 idle stop evt", evt_o, 7'h01);

    // loop mode, two passes
    clear_all();
    check("R9 cleared", flags_o, 0);
    loop_cnt = 2;
    task_start0 = 1; step1();
    check("R4 start evt", evt_o, 7'h02);
    seq_done = 1; step1();
    check("R4 switch to 1 evt", evt_o, 7'h0C);
    check("R4 sel 1", seq_sel_o, 1);
    check("R4 reload", seq_load_o, 1);
    check("R5 not final pass", final_pass_o, 0);
    seq_done = 1; step1();
    check("R4 back to 0 evt", evt_o, 7'h12);
    check("R4 sel 0", seq_sel_o, 0);
    seq_done = 1; step1();
    check("R4 sel 1 again", seq_sel_o, 1);
    check("R5 final pass", final_pass_o, 1);
    seq_done = 1; step1();
    check("R4 loops done evt", evt_o, 7'h50);
    check("R5 final cleared", final_pass_o, 0);
    check("R4 hold run", run_o, 1);
    seq_done = 1; step1();
    check("R4 hold no evt", evt_o, 0);
    check("R9 sticky flags", flags_o, 7'h5E);
    period_end = 1; step1();
    check("R9 period flag", flags_o[5], 1);
    period_end = 1; evt_clr = 7'h20; step1();
    check("R9 clear loses to event", flags_o[5], 1);
    evt_clr = 7'h20; step1();
    check("R9 clear", flags_o, 7'h5E);
    for (int i = 0; i < 8; i++) begin
      int_en = 7'($urandom);
      #1;
      check("R10 irq", irq_o, exp_irq(flags_o, int_en));
      step1();
    end
    int_en = 7'h01; #1;
    check("R10 masked flag", irq_o, 0);
    int_en = '0;
    to_idle();

    // shortcut loops-done to start 1
    short_en = 5'b01000; loop_cnt = 1;
    task_start0 = 1; step1();
    seq_done = 1; step1();
    check("R5 final one pass", final_pass_o, 1);
    seq_done = 1; step1();
    check("R8 loops evt", evt_o, 7'h50);
    step1();
    check("R8 shortcut started1", evt_o, 7'h04);
    check("R8 shortcut sel", seq_sel_o, 1);
    check("R8 shortcut load", seq_load_o, 1);
    seq_done = 1; step1();
    check("R4 start on 1 single strobe", evt_o, 7'h50);
    short_en = '0; step1();
    check("R8 disabled no restart", seq_load_o, 0);
    to_idle();

    // shortcut end0 to stop
    short_en = 5'b00001; loop_cnt = 3;
    task_start0 = 1; step1();
    seq_done = 1; step1();
    check("R8 end0 evt", evt_o[3], 1);
    step1();
    check("R8 end0 stop shortcut", stop_req_o, 1);
    period_end = 1; step1();
    check("R8 stopped", evt_o[0], 1);
    short_en = '0;

    // start priorities and restart
    loop_cnt = 0;
    task_start0 = 1; task_start1 = 1; task_stop = 1; step1();
    check("R2 start beats stop", stop_req_o, 0);
    check("R2 seq0 wins", evt_o, 7'h02);
    task_start1 = 1; step1();
    check("R2 restart sel", seq_sel_o, 1);
    check("R2 restart evt", evt_o, 7'h04);
    to_idle();

    // restart reloads loop count
    loop_cnt = 3;
    task_start0 = 1; step1();
    seq_done = 1; step1();
    task_start0 = 1; step1();
    check("R2 restart to seq0", seq_sel_o, 0);
    cnt = 0;
    for (int k = 0; k < 20; k++) begin
      seq_done = 1; step1();
      cnt++;
      if (evt_o[6]) break;
    end
    check("R2 reloaded count", cnt, 6);
    to_idle();

    // random loop counts and start sequences
    for (int it = 0; it < 12; it++) begin
      n = $urandom_range(1, 4);
      s = 1'($urandom_range(0, 1));
      loop_cnt = LW'(n);
      task_start0 = !s; task_start1 = s; step1();
      check("R2 random sel", seq_sel_o, s);
      cnt = 0; e0 = 0;
      for (int k = 0; k < 20; k++) begin
        seq_done = 1; step1();
        cnt++;
        if (evt_o[3]) e0++;
        if (evt_o[6]) break;
      end
      check("R4 random strobes", cnt, strobes_to_done(n, s));
      check("R4 random end0 count", e0, end0_count(n, s));
      to_idle();
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule